// File: doc/BRIEF.md
# Triggered Double-Pulse Generator

This block produces a single burst of two pulses each time its trigger input rises. It is meant for switching tests of power transistors. The first pulse charges the load. The second pulse, which is wider, switches the device again under current. An up/down triangle counter runs all the time between zero and a programmable peak. Two programmable thresholds, together with the peak, shape both pulses inside one triangle period.

A trip latch forces the output low between bursts. The trip state is decided only when the counter is at zero. A trigger edge that has been captured since the last decision releases the trip for exactly one triangle period. With no captured edge, the trip is set again. Because of this, a burst always starts and ends cleanly at counter zero, and it cannot be cut short.

The peak and threshold inputs feed shadow registers that load only at counter zero. Software can rewrite them at any time without disturbing a burst that is already running. All counts are in clock cycles. With a 100 MHz clock and the default values 400/100/200, the triangle period is 8 µs, the first pulse is 1 µs and the second pulse is 2 µs.

Top module: `dpg_burst_gen`

## Requirements
- R1: While reset is asserted and in the cycles right after it, `pulse_o` and `busy_o` are both low, and the trip starts in the set state.
- R2: With no rising edge on `trig_i`, `pulse_o` and `busy_o` stay low indefinitely.
- R3: For settings with 1 ≤ cmpa < cmpb < prd, the first pulse rises `cmpa` cycles after `busy_o` rises and stays high for `cmpb − cmpa` cycles.
- R4: The low gap between the two pulses lasts `prd − cmpb` cycles.
- R5: The second pulse is high for `prd − cmpb` cycles and ends before `busy_o` falls.
- R6: One trigger edge gives exactly two pulses. `busy_o` is high for `2·prd` cycles, and `pulse_o` is never high while `busy_o` is low.
- R7: `prd_i`, `cmpa_i` and `cmpb_i` take effect only at counter zero. A change made during a burst leaves that burst unchanged and applies to the next one.
- R8: A trigger edge that arrives while `busy_o` is high is held and starts a second burst directly after the first. `busy_o` then stays high for `4·prd` cycles and gives four pulses.
- R9: The trigger acts on edges. Holding `trig_i` high gives only one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger; a rising edge requests one burst |
| prd_i | input | W | Triangle peak count (half period) |
| cmpa_i | input | W | Up-slope threshold that starts the first pulse |
| cmpb_i | input | W | Threshold that ends the first pulse (up) and the second pulse (down) |
| pulse_o | output | 1 | Double-pulse output |
| busy_o | output | 1 | High while the trip is released |

## Verification
The assertions assume that the settings seen at each counter-zero load satisfy 1 ≤ cmpa < cmpb < prd. Under that assumption the four counter events never coincide, and each edge of `pulse_o` can be traced to one event. One check states this assumption directly on the inputs at zero. The stimulus keeps every configuration inside this range, including the tightest case (3/1/2). It changes settings only while idle or at a chosen point inside a burst. It holds each trigger high long enough to pass the synchronizer.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic zero;
    logic cmpa_up;
    logic cmpb_up;
    logic peak;
    logic cmpb_dn;
  } tb_evt_t;

  function automatic logic cfg_ok(input int unsigned prd, input int unsigned ca,
                                  input int unsigned cb);
    return (ca >= 1) && (ca < cb) && (cb < prd);
  endfunction

  function automatic int unsigned lead_len(input int unsigned ca);
    return ca;
  endfunction

  function automatic int unsigned first_len(input int unsigned ca, input int unsigned cb);
    return cb - ca;
  endfunction

  function automatic int unsigned second_len(input int unsigned prd, input int unsigned cb);
    return prd - cb;
  endfunction

  function automatic int unsigned burst_len(input int unsigned prd);
    return 2 * prd;
  endfunction

endpackage

// File: rtl/dpg_trig_sync.sv
module dpg_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  input  logic consume_i,
  output logic req_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              req_q;
  logic              rise;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q[g] <= 1'b0;
        else       sync_q[g] <= trig_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q[g] <= 1'b0;
        else       sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign rise = sync_q[LAST] & ~hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hist_q <= sync_q[LAST];
      req_q  <= rise | (req_q & ~consume_i);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dpg_timebase.sv
module dpg_timebase
  import dpg_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEF_PRD  = 400,
  parameter int DEF_CMPA = 100,
  parameter int DEF_CMPB = 200
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] prd_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  output tb_evt_t      evt_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] act_prd_o,
  output dir_e         dir_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, prd_q, cmpa_q, cmpb_q;
  dir_e         dir_q;

  always_comb begin
    evt_o.zero    = (cnt_q == '0);
    evt_o.cmpa_up = (dir_q == DIR_UP)   && (cnt_q == cmpa_q);
    evt_o.cmpb_up = (dir_q == DIR_UP)   && (cnt_q == cmpb_q);
    evt_o.peak    = (cnt_q == prd_q);
    evt_o.cmpb_dn = (dir_q == DIR_DOWN) && (cnt_q == cmpb_q);
  end

  // Shadow values are refreshed only at zero so a running burst is never altered.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      prd_q  <= W'(DEF_PRD);
      cmpa_q <= W'(DEF_CMPA);
      cmpb_q <= W'(DEF_CMPB);
    end else if (evt_o.zero) begin
      cnt_q  <= ONE;
      dir_q  <= DIR_UP;
      prd_q  <= prd_i;
      cmpa_q <= cmpa_i;
      cmpb_q <= cmpb_i;
    end else if (evt_o.peak) begin
      cnt_q  <= cnt_q - ONE;
      dir_q  <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q  <= cnt_q + ONE;
    end else begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  assign cnt_o     = cnt_q;
  assign act_prd_o = prd_q;
  assign dir_o     = dir_q;
endmodule

// File: rtl/dpg_wave.sv
module dpg_wave
  import dpg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  tb_evt_t evt_i,
  input  logic    req_i,
  output logic    consume_o,
  output logic    trip_o,
  output logic    pulse_o
);
  logic raw_q;
  logic trip_q;

  assign consume_o = evt_i.zero & req_i;

  // Action qualifier: each counter event sets the raw level; trip masks it.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      raw_q  <= 1'b0;
      trip_q <= 1'b1;
    end else begin
      if (evt_i.zero) trip_q <= ~req_i;
      if (evt_i.cmpa_up || evt_i.peak)         raw_q <= 1'b1;
      else if (evt_i.cmpb_up || evt_i.cmpb_dn) raw_q <= 1'b0;
    end
  end

  assign trip_o  = trip_q;
  assign pulse_o = raw_q & ~trip_q;
endmodule

// File: rtl/dpg_burst_gen.sv
module dpg_burst_gen
  import dpg_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_PRD     = 400,
  parameter int DEF_CMPA    = 100,
  parameter int DEF_CMPB    = 200
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         trig_i,
  input  logic [W-1:0] prd_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  output logic         pulse_o,
  output logic         busy_o
);
  tb_evt_t      evt;
  logic [W-1:0] cnt;
  logic [W-1:0] act_prd;
  dir_e         dir;
  logic         req_pend;
  logic         consume;
  logic         trip;

  // Named event wires for the checker.
  logic zero_evt, cmpa_up, cmpb_up, peak_evt, cmpb_dn;
  assign zero_evt = evt.zero;
  assign cmpa_up  = evt.cmpa_up;
  assign cmpb_up  = evt.cmpb_up;
  assign peak_evt = evt.peak;
  assign cmpb_dn  = evt.cmpb_dn;

  dpg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .trig_i    (trig_i),
    .consume_i (consume),
    .req_o     (req_pend)
  );

  dpg_timebase #(
    .W(W), .DEF_PRD(DEF_PRD), .DEF_CMPA(DEF_CMPA), .DEF_CMPB(DEF_CMPB)
  ) u_tb (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .prd_i     (prd_i),
    .cmpa_i    (cmpa_i),
    .cmpb_i    (cmpb_i),
    .evt_o     (evt),
    .cnt_o     (cnt),
    .act_prd_o (act_prd),
    .dir_o     (dir)
  );

  dpg_wave u_wave (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .evt_i     (evt),
    .req_i     (req_pend),
    .consume_o (consume),
    .trip_o    (trip),
    .pulse_o   (pulse_o)
  );

  assign busy_o = ~trip;
endmodule

// File: rtl/dpg_burst_gen_chk.sv
module dpg_burst_gen_chk
  import dpg_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         pulse_o,
  input logic         busy_o,
  input logic         zero_evt,
  input logic         cmpa_up,
  input logic         cmpb_up,
  input logic         peak_evt,
  input logic         cmpb_dn,
  input logic         req_pend,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_prd,
  input logic [W-1:0] prd_i,
  input logic [W-1:0] cmpa_i,
  input logic [W-1:0] cmpb_i,
  input dir_e         dir
);
  a_r3_cfg_valid_at_load: assert property (@(posedge clk_i) disable iff (rst_i)
    zero_evt |-> cfg_ok(int'(prd_i), int'(cmpa_i), int'(cmpb_i)));

  a_r6_no_pulse_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |-> busy_o);

  a_r3_rise_from_event: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pulse_o) |-> $past(cmpa_up || peak_evt));

  a_r5_fall_from_event: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pulse_o) |-> $past(cmpb_up || cmpb_dn));

  a_r8_release_on_request: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_evt && req_pend) |=> busy_o);

  a_r2_trip_without_request: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_evt && !req_pend) |=> !busy_o);

  a_r7_shadow_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    !zero_evt |=> $stable(act_prd));

  a_r6_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= act_prd);

  a_r4_turn_at_peak: assert property (@(posedge clk_i) disable iff (rst_i)
    (peak_evt && !zero_evt) |=> (dir == DIR_DOWN));
endmodule

bind dpg_burst_gen dpg_burst_gen_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .pulse_o  (pulse_o),
  .busy_o   (busy_o),
  .zero_evt (zero_evt),
  .cmpa_up  (cmpa_up),
  .cmpb_up  (cmpb_up),
  .peak_evt (peak_evt),
  .cmpb_dn  (cmpb_dn),
  .req_pend (req_pend),
  .cnt      (cnt),
  .act_prd  (act_prd),
  .prd_i    (prd_i),
  .cmpa_i   (cmpa_i),
  .cmpb_i   (cmpb_i),
  .dir      (dir)
);

// File: tb/dpg_burst_gen_tb.sv
module dpg_burst_gen_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig = 1'b0;
  logic [W-1:0] prd = 16'd400, ca = 16'd100, cb = 16'd200;
  logic         pulse, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dpg_burst_gen #(.W(W)) u_dut (
    .clk_i(clk), .rst_i(rst), .trig_i(trig),
    .prd_i(prd), .cmpa_i(ca), .cmpb_i(cb),
    .pulse_o(pulse), .busy_o(busy)
  );

  // {prd, cmpa, cmpb}
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{400, 100, 200},
    '{ 20,   3,   9},
    '{ 10,   1,   2},
    '{  6,   2,   5},
    '{  3,   1,   2}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic set_cfg(input int p, input int a, input int b);
    prd = W'(p); ca = W'(a); cb = W'(b);
  endtask

  // mode 0: plain, 1: rewrite config at sample 3, 2: retrigger at sample 10
  task automatic run_burst(input int mode, input int p2, input int a2, input int b2,
                           output int lead, output int w1, output int gap,
                           output int w2, output int blen, output int np);
    int k = 0; int r = 0; int f1 = 0; bit prev = 0; int wait_c = 0;
    lead = -1; w1 = -1; gap = -1; w2 = -1; np = 0;
    @(negedge clk);
    while (!busy && wait_c < 3000) begin @(negedge clk); wait_c++; end
    while (busy) begin
      if (mode == 1 && k == 3) set_cfg(p2, a2, b2);
      if (mode == 2 && k == 10) trig = 1'b1;
      if (mode == 2 && k == 13) trig = 1'b0;
      if (pulse && !prev) begin
        np++; r = k;
        if (np == 1) lead = k;
        if (np == 2) gap = k - f1;
      end
      if (!pulse && prev) begin
        if (np == 1) begin w1 = k - r; f1 = k; end
        if (np == 2) w2 = k - r;
      end
      prev = pulse; k++;
      @(negedge clk);
    end
    blen = k;
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || pulse) hits++;
    end
  endtask

  initial begin
    int lead, w1, gap, w2, blen, np, hits;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(!pulse && !busy, "R1 outputs during reset", {pulse, busy}, 0);
    rst = 1'b0;
    quiet(3, hits);
    check(hits == 0, "R1 outputs after reset", hits, 0);

    // R2: no trigger
    quiet(1000, hits);
    check(hits == 0, "R2 idle without trigger", hits, 0);

    // Vector table: R3, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      int p = VEC[v][0]; int a = VEC[v][1]; int b = VEC[v][2];
      set_cfg(p, a, b);
      fire();
      run_burst(0, 0, 0, 0, lead, w1, gap, w2, blen, np);
      check(lead == a,         $sformatf("R3 lead v%0d", v), lead, a);
      check(w1 == b - a,       $sformatf("R3 first width v%0d", v), w1, b - a);
      check(gap == p - b,      $sformatf("R4 gap v%0d", v), gap, p - b);
      check(w2 == p - b,       $sformatf("R5 second width v%0d", v), w2, p - b);
      check(blen == 2 * p,     $sformatf("R6 busy length v%0d", v), blen, 2 * p);
      check(np == 2,           $sformatf("R6 pulse count v%0d", v), np, 2);
      quiet(2 * p + 10, hits);
      check(hits == 0,         $sformatf("R6 quiet after v%0d", v), hits, 0);
    end

    // R7: mid-burst rewrite does not disturb the running burst
    set_cfg(20, 3, 9);
    fire();
    run_burst(1, 10, 1, 2, lead, w1, gap, w2, blen, np);
    check(w1 == 6 && gap == 11 && w2 == 11, "R7 burst kept old widths", w1 * 100 + w2, 611);
    check(blen == 40, "R7 burst kept old length", blen, 40);
    fire();
    run_burst(0, 0, 0, 0, lead, w1, gap, w2, blen, np);
    check(lead == 1 && w1 == 1 && w2 == 8, "R7 next burst uses new cfg", lead * 100 + w1 * 10 + w2, 118);
    check(blen == 20, "R7 next burst length", blen, 20);

    // R8: trigger during busy is queued
    set_cfg(20, 3, 9);
    fire();
    run_burst(2, 0, 0, 0, lead, w1, gap, w2, blen, np);
    check(blen == 80, "R8 back-to-back busy length", blen, 80);
    check(np == 4, "R8 back-to-back pulse count", np, 4);
    quiet(50, hits);
    check(hits == 0, "R8 quiet after queued burst", hits, 0);

    // R9: level held high gives one burst
    @(negedge clk) trig = 1'b1;
    run_burst(0, 0, 0, 0, lead, w1, gap, w2, blen, np);
    check(np == 2 && blen == 40, "R9 single burst while held", np * 100 + blen, 240);
    quiet(120, hits);
    check(hits == 0, "R9 no repeat while held", hits, 0);
    trig = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule